// File: doc/BRIEF.md
# Handshaking Parallel I/O Port

This block moves bytes between a processor and an external device over two independent 8-bit paths. On the inward path the device places a byte on its data lines and raises a strobe. The port captures the byte, lowers its ready line to show that the buffer is occupied, and can interrupt the processor. The processor then reads the byte, which frees the buffer and raises the ready line again. On the outward path the processor writes a byte. The port drives that byte to the device and raises a full line. The device raises an acknowledge once it has taken the byte, which empties the buffer and can interrupt the processor for the next byte.

Strobe and acknowledge come from outside the clock domain. Each passes through a chain of synchronizing flops, and only its rising edge is acted on. The processor side is a small register port with four word addresses: input data, output data, interrupt enables and status. The single interrupt line is the OR of two enabled causes: input buffer full and output buffer empty.

Top module: `hs_parallel_port`

## Requirements
- R1: After reset `port_rdy` is 1, `buf_full` is 0 and `irq` is 0. The status register (address 3: bit 0 input full, bit 1 output empty, bit 2 overrun) reads 8'h02.
- R2: A rising edge on `dev_stb` captures `dev_in_data` into the input buffer when the buffer is empty. `port_rdy` falls at the third clock edge after the strobe rises, counting the two synchronizer flops, and not earlier.
- R3: A read of address 0 returns the captured byte. At the clock edge that ends the read cycle the input buffer empties and `port_rdy` returns to 1.
- R4: While control bit 0 (address 2) is 1 and the input buffer is full, `irq` is 1. With that bit at 0, a full input buffer leaves `irq` at 0.
- R5: A strobe rising edge that arrives while the input buffer is full is ignored: the buffered byte is unchanged, and status bit 2 (overrun) is set. Writing a 1 to bit 2 of address 3 clears it.
- R6: A write to address 1 while the output buffer is empty loads the byte onto `dev_out_data` and raises `buf_full` at that clock edge. A write while the buffer is full is ignored.
- R7: A rising edge on `dev_ack` empties the output buffer. `buf_full` falls at the third clock edge after `dev_ack` rises. An acknowledge held high does not empty a byte written later.
- R8: While control bit 1 is 1 and the output buffer is empty, `irq` is 1. It goes to 0 as soon as a byte is written.
- R9: Address 2 reads back the two enable bits in bits 1:0, and `irq` is the OR of the two enabled causes.
- R10: Only strobe edges capture data. A strobe held high after the buffer has been read does not capture again, so `port_rdy` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_in_data | input | 8 | Byte offered by the device |
| dev_stb | input | 1 | Device strobe, asynchronous |
| port_rdy | output | 1 | High while the input buffer can accept a byte |
| dev_out_data | output | 8 | Byte held for the device |
| buf_full | output | 1 | High while the output buffer holds an untaken byte |
| dev_ack | input | 1 | Device acknowledge, asynchronous |
| reg_addr | input | 2 | Register address: 0 input data, 1 output data, 2 control, 3 status |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of address 0 frees the input buffer |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from the addressed register |
| irq | output | 1 | Interrupt request |

## Verification
Device-side events are due at the third rising clock edge after the strobe or acknowledge input changes: two edges for the synchronizer and one for the buffer register. The bench changes these inputs on a falling edge, confirms that the output has not yet moved two falling edges later, and checks the new value one falling edge after that. Register writes and reads take effect at the single edge inside their one-cycle access. Read data is queued as an expected value and compared mid-cycle, and `irq`, `port_rdy` and `buf_full` are sampled at the falling edge after the access.

// File: rtl/pp_pkg.sv
package pp_pkg;

    typedef enum logic [1:0] {
        ADR_IN_DATA  = 2'd0,
        ADR_OUT_DATA = 2'd1,
        ADR_CTRL     = 2'd2,
        ADR_STATUS   = 2'd3
    } pp_addr_e;

    localparam int CTRL_EN_IN   = 0;
    localparam int CTRL_EN_OUT  = 1;
    localparam int ST_IN_FULL   = 0;
    localparam int ST_OUT_EMPTY = 1;
    localparam int ST_OVERRUN   = 2;

endpackage

// File: rtl/pp_sync_edge.sv
module pp_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);

    localparam int TOP = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        st_d.last = st_q.chain[TOP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o = st_q.chain[TOP] & ~st_q.last;

    // R10: a detected edge lasts exactly one cycle
    p_rise_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/pp_in_chan.sv
module pp_in_chan #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_rise,
    input  logic [DATA_W-1:0] dev_data,
    input  logic              pop,
    input  logic              ovr_clr,
    output logic              full_o,
    output logic              ovr_o,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic              full;
        logic              ovr;
        logic [DATA_W-1:0] data;
    } in_st_t;

    in_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pop) begin
            st_d.full = 1'b0;
        end
        if (ovr_clr) begin
            st_d.ovr = 1'b0;
        end
        if (stb_rise) begin
            if (!st_q.full || pop) begin
                st_d.full = 1'b1;
                st_d.data = dev_data;
            end else begin
                st_d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full_o = st_q.full;
    assign ovr_o  = st_q.ovr;
    assign data_o = st_q.data;

    // R2: an edge on an empty buffer captures the device byte
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stb_rise && !full_o |=> full_o && (data_o == $past(dev_data)));

    // R5: an edge on a full buffer keeps the byte and flags overrun
    p_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stb_rise && full_o && !pop |=> ovr_o && $stable(data_o));

    // R3: a processor read without a new edge empties the buffer
    p_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pop && !stb_rise |=> !full_o);

endmodule

// File: rtl/pp_out_chan.sv
module pp_out_chan #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack_rise,
    output logic              full_o,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ack_rise) begin
            st_d.full = 1'b0;
        end
        if (wr && (!st_q.full || ack_rise)) begin
            st_d.full = 1'b1;
            st_d.data = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full_o = st_q.full;
    assign data_o = st_q.data;

    // R6: a write to an empty buffer loads it
    p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr && !full_o |=> full_o && (data_o == $past(wdata)));

    // R6: a write to a full buffer is dropped
    p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr && full_o && !ack_rise |=> $stable(data_o) && full_o);

    // R7: an acknowledge edge with no new write empties the buffer
    p_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rise && !wr |=> !full_o);

endmodule

// File: rtl/hs_parallel_port.sv
module hs_parallel_port
    import pp_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] dev_in_data,
    input  logic              dev_stb,
    output logic              port_rdy,
    output logic [DATA_W-1:0] dev_out_data,
    output logic              buf_full,
    input  logic              dev_ack,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    typedef struct packed {
        logic en_in;
        logic en_out;
    } ctrl_st_t;

    ctrl_st_t ctrl_d, ctrl_q;

    pp_addr_e          addr;
    logic              stb_rise, ack_rise;
    logic              in_pop, ovr_clr, out_wr;
    logic              in_full, in_ovr, out_full;
    logic [DATA_W-1:0] in_data;

    assign addr    = pp_addr_e'(reg_addr);
    assign in_pop  = reg_rd && (addr == ADR_IN_DATA);
    assign out_wr  = reg_wr && (addr == ADR_OUT_DATA);
    assign ovr_clr = reg_wr && (addr == ADR_STATUS) && reg_wdata[ST_OVERRUN];

    pp_sync_edge #(.STAGES(SYNC_STAGES)) u_stb_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(dev_stb),
        .rise_o (stb_rise)
    );

    pp_sync_edge #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(dev_ack),
        .rise_o (ack_rise)
    );

    pp_in_chan #(.DATA_W(DATA_W)) u_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb_rise(stb_rise),
        .dev_data(dev_in_data),
        .pop     (in_pop),
        .ovr_clr (ovr_clr),
        .full_o  (in_full),
        .ovr_o   (in_ovr),
        .data_o  (in_data)
    );

    pp_out_chan #(.DATA_W(DATA_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (out_wr),
        .wdata   (reg_wdata),
        .ack_rise(ack_rise),
        .full_o  (out_full),
        .data_o  (dev_out_data)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (reg_wr && (addr == ADR_CTRL)) begin
            ctrl_d.en_in  = reg_wdata[CTRL_EN_IN];
            ctrl_d.en_out = reg_wdata[CTRL_EN_OUT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (addr)
            ADR_IN_DATA:  reg_rdata = in_data;
            ADR_OUT_DATA: reg_rdata = dev_out_data;
            ADR_CTRL: begin
                reg_rdata[CTRL_EN_IN]  = ctrl_q.en_in;
                reg_rdata[CTRL_EN_OUT] = ctrl_q.en_out;
            end
            ADR_STATUS: begin
                reg_rdata[ST_IN_FULL]   = in_full;
                reg_rdata[ST_OUT_EMPTY] = ~out_full;
                reg_rdata[ST_OVERRUN]   = in_ovr;
            end
            default: reg_rdata = '0;
        endcase
    end

    assign port_rdy = ~in_full;
    assign buf_full = out_full;
    assign irq      = (ctrl_q.en_in & in_full) | (ctrl_q.en_out & ~out_full);

    // R3: the ready line only returns after a processor read of the input data
    p_rdy_return_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(port_rdy) |-> $past(in_pop));

    // R7: the full line only drops after a synchronized acknowledge edge
    p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buf_full) |-> $past(ack_rise));

    // R4: with both enables clear no interrupt is raised
    p_irq_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.en_in && !ctrl_q.en_out |-> !irq);

endmodule

// File: tb/hs_parallel_port_tb.sv
`timescale 1ns/1ps
module hs_parallel_port_tb;

    localparam real HALF = 2.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] dev_in_data = '0;
    logic       dev_stb = 1'b0;
    logic       port_rdy;
    logic [7:0] dev_out_data;
    logic       buf_full;
    logic       dev_ack = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    event       mon_ev;

    always #(HALF) clk = ~clk;

    hs_parallel_port u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .dev_in_data (dev_in_data),
        .dev_stb     (dev_stb),
        .port_rdy    (port_rdy),
        .dev_out_data(dev_out_data),
        .buf_full    (buf_full),
        .dev_ack     (dev_ack),
        .reg_addr    (reg_addr),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .irq         (irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data and compares it mid-cycle
    always @(mon_ev) begin
        if (exp_q.size() > 0) begin
            chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
        end
    end

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        reg_rd   = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        #(HALF / 2);
        -> mon_ev;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    initial begin
        #(HALF * 2 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(1);

        // reset state
        chk("R1 port_rdy", port_rdy, 1);
        chk("R1 buf_full", buf_full, 0);
        chk("R1 irq", irq, 0);
        reg_read(2'd3, 8'h02, "R1 status");

        // first capture, interrupts disabled
        dev_in_data = 8'hA5;
        dev_stb = 1'b1;
        wait_neg(2);
        chk("R2 port_rdy before sync", port_rdy, 1);
        wait_neg(1);
        chk("R2 port_rdy after capture", port_rdy, 0);
        chk("R4 irq masked", irq, 0);
        reg_write(2'd2, 8'h01);
        chk("R4 irq in full", irq, 1);
        reg_read(2'd2, 8'h01, "R9 ctrl readback");
        reg_read(2'd3, 8'h03, "R3 status full");

        // overrun: second edge while full
        dev_stb = 1'b0;
        dev_in_data = 8'h3C;
        wait_neg(3);
        dev_stb = 1'b1;
        wait_neg(4);
        reg_read(2'd3, 8'h07, "R5 overrun set");
        reg_read(2'd0, 8'hA5, "R5 byte kept / R3 read");
        chk("R3 port_rdy after read", port_rdy, 1);
        chk("R4 irq after read", irq, 0);
        wait_neg(5);
        chk("R10 held strobe no capture", port_rdy, 1);
        reg_write(2'd3, 8'h04);
        reg_read(2'd3, 8'h02, "R5 overrun cleared");

        // second capture
        dev_stb = 1'b0;
        wait_neg(3);
        dev_in_data = 8'h5A;
        dev_stb = 1'b1;
        wait_neg(3);
        chk("R2 second capture rdy", port_rdy, 0);
        reg_read(2'd0, 8'h5A, "R2 second byte");
        dev_stb = 1'b0;

        // output path
        reg_write(2'd2, 8'h02);
        chk("R8 irq out empty", irq, 1);
        reg_write(2'd1, 8'hC3);
        chk("R6 buf_full", buf_full, 1);
        chk("R6 out data", dev_out_data, 8'hC3);
        chk("R8 irq after write", irq, 0);
        reg_write(2'd1, 8'h99);
        chk("R6 write while full ignored", dev_out_data, 8'hC3);
        dev_ack = 1'b1;
        wait_neg(2);
        chk("R7 full before sync", buf_full, 1);
        wait_neg(1);
        chk("R7 emptied by ack", buf_full, 0);
        chk("R8 irq empty again", irq, 1);
        reg_write(2'd1, 8'h77);
        wait_neg(6);
        chk("R7 held ack keeps full", buf_full, 1);
        chk("R7 new byte", dev_out_data, 8'h77);
        dev_ack = 1'b0;
        wait_neg(3);
        dev_ack = 1'b1;
        wait_neg(3);
        chk("R7 second ack", buf_full, 0);
        dev_ack = 1'b0;

        // OR of both causes
        reg_write(2'd2, 8'h03);
        chk("R9 irq both enabled", irq, 1);
        reg_write(2'd1, 8'h11);
        chk("R9 irq both idle", irq, 0);
        dev_in_data = 8'hE7;
        dev_stb = 1'b1;
        wait_neg(3);
        chk("R9 irq from input", irq, 1);
        reg_write(2'd2, 8'h02);
        chk("R9 irq input masked", irq, 0);
        reg_read(2'd0, 8'hE7, "R3 third byte");

        wait_neg(2);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule